// File: doc/BRIEF.md
# Adapter command decoder and event-status register

This block is the host-side control core of a network adapter. The host writes 16-bit command words. The upper five bits of each word select an operation and the lower eleven bits carry its argument. The block keeps the selected register window and a set of sticky event flags. It also holds an interrupt-enable mask, a read-visibility mask and two FIFO threshold values. From this state it derives a 16-bit status word and an interrupt request.

Pulses from the transmit, receive and statistics engines arrive on `evt_i` and are latched into the event flags. The host clears flags with an acknowledge command whose argument is a bit mask. The block drives level enables and one-cycle reset strobes back to the transmit and receive engines. A countdown marks the status word busy for two cycles after any command that resets or enables an engine.

Top module: `nic_cmd_status`

## Requirements
- R1: After reset:
  - status_o reads 0 and irq_o is 0.
  - The window is 0.
  - The event flags, interrupt mask and read-visibility mask are 0.
  - rx_en_o and tx_en_o are 0.
  - Both thresholds read 2047.
- R2: Opcode 1 (command bits 15:11) selects the window from argument bits 2:0, and status bits 15:13 return it. Argument bits 10:3 have no effect.
- R3: A 1 on evt_i bit 1, 2, 3, 4, 5 or 7 sets the same status flag bit. The flag holds until it is acknowledged. evt_i bits 0 and 6 have no effect.
- R4: Opcode 0x0D clears each flag whose bit is set in argument bits 7:0. If an event sets a flag in the same cycle, the event wins.
- R5: Opcode 0x0C sets flag bit 6.
- R6: Opcode 0x0E loads the interrupt mask from argument bits 7:0. irq_o is 1 exactly when some flag is set whose mask bit is also set.
- R7: Flag bit 0 is set whenever a newly arriving flag bit (1 to 7) is enabled in the interrupt mask.
- R8: Opcode 0x0F loads the read-visibility mask from argument bits 7:0. Status bits 7:0 are the flags ANDed with this mask. Hidden flags keep their state.
- R9: Receiver control uses opcode 3 (disable) and opcode 4 (enable) on rx_en_o. Transmitter control uses opcode 0x0A (disable) and opcode 9 (enable) on tx_en_o.
- R10: Opcode 5 raises rx_rst_o, and opcode 0x0B raises tx_rst_o. Each strobe is high for exactly the one cycle after the command.
- R11: Status bit 12 is high for the two cycles after opcode 0, 4, 5, 9 or 0x0B. Other opcodes do not raise it.
- R12: Opcode 0x11 loads the RX-early threshold and opcode 0x12 loads the TX-available threshold, each from argument bits 10:0. While a threshold equals 2047, its event input (evt_i bit 5 or bit 3 respectively) is ignored.
- R13: Opcode 0 does the following:
  - clears the flags and both masks;
  - sets the window to 0;
  - disables the receiver and transmitter;
  - sets both thresholds to 2047;
  - pulses both reset strobes.
- R14: Opcodes without a defined meaning change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode 15:11, argument 10:0 |
| evt_i | input | 8 | Event pulses, bit positions match status bits |
| status_o | output | 16 | Window, busy flag and visible event flags |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_rst_o | output | 1 | Receiver reset strobe |
| tx_rst_o | output | 1 | Transmitter reset strobe |
| rxe_thr_o | output | 11 | RX-early threshold |
| txa_thr_o | output | 11 | TX-available threshold |

## Verification
The hardest case to reach is an acknowledge and an event on the same flag in one cycle. Two related cases are a flag that is hidden by the visibility mask but still latched, and a threshold event that is ignored while its threshold is at the disable value.

The stimulus table drives the first case directly by pairing an acknowledge command with an event in the same vector. It hides a flag, shows that the flag reads 0, and then reopens the mask to prove the flag survived. It sends a TX-available pulse before and after loading a threshold, so that both the ignored and the accepted event are seen at the status port.

// File: rtl/nic_cmd_status.sv
module nic_cmd_status #(
  parameter int BUSY_CYC = 2,
  parameter int ARG_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [15:0]      cmd_data,
  input  logic [7:0]       evt_i,
  output logic [15:0]      status_o,
  output logic             irq_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             rx_rst_o,
  output logic             tx_rst_o,
  output logic [ARG_W-1:0] rxe_thr_o,
  output logic [ARG_W-1:0] txa_thr_o
);
  localparam logic [ARG_W-1:0] THR_OFF = '1;
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] BUSY_LD = CW'(BUSY_CYC);

  logic [4:0]       op;
  logic [ARG_W-1:0] arg;
  assign op  = cmd_data[15:11];
  assign arg = cmd_data[ARG_W-1:0];

  logic is_grst, is_win, is_rxdis, is_rxen, is_rxrst, is_txen, is_txdis, is_txrst;
  logic is_req, is_ack, is_imask, is_rzmask, is_rxethr, is_txathr;
  assign is_grst   = cmd_we && op == 5'h00;
  assign is_win    = cmd_we && op == 5'h01;
  assign is_rxdis  = cmd_we && op == 5'h03;
  assign is_rxen   = cmd_we && op == 5'h04;
  assign is_rxrst  = cmd_we && op == 5'h05;
  assign is_txen   = cmd_we && op == 5'h09;
  assign is_txdis  = cmd_we && op == 5'h0A;
  assign is_txrst  = cmd_we && op == 5'h0B;
  assign is_req    = cmd_we && op == 5'h0C;
  assign is_ack    = cmd_we && op == 5'h0D;
  assign is_imask  = cmd_we && op == 5'h0E;
  assign is_rzmask = cmd_we && op == 5'h0F;
  assign is_rxethr = cmd_we && op == 5'h11;
  assign is_txathr = cmd_we && op == 5'h12;

  logic [2:0]    win;
  logic [7:0]    lat, imask, rzmask;
  logic [CW-1:0] busy_cnt;

  logic [7:0] src, set_v, ack_v;
  always_comb begin
    src    = evt_i & 8'b1011_1110;
    src[3] = evt_i[3] && (txa_thr_o != THR_OFF);
    src[5] = evt_i[5] && (rxe_thr_o != THR_OFF);
    src[6] = is_req;
    set_v    = src;
    set_v[0] = |(src[7:1] & imask[7:1]);
    ack_v    = is_ack ? arg[7:0] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0; lat <= '0; imask <= '0; rzmask <= '0; busy_cnt <= '0;
      rx_en_o <= 1'b0; tx_en_o <= 1'b0; rx_rst_o <= 1'b0; tx_rst_o <= 1'b0;
      rxe_thr_o <= THR_OFF; txa_thr_o <= THR_OFF;
    end else if (is_grst) begin
      win <= '0; lat <= '0; imask <= '0; rzmask <= '0; busy_cnt <= BUSY_LD;
      rx_en_o <= 1'b0; tx_en_o <= 1'b0; rx_rst_o <= 1'b1; tx_rst_o <= 1'b1;
      rxe_thr_o <= THR_OFF; txa_thr_o <= THR_OFF;
    end else begin
      lat      <= (lat & ~ack_v) | set_v;
      rx_rst_o <= is_rxrst;
      tx_rst_o <= is_txrst;
      if (is_win)    win <= arg[2:0];
      if (is_imask)  imask <= arg[7:0];
      if (is_rzmask) rzmask <= arg[7:0];
      if (is_rxethr) rxe_thr_o <= arg;
      if (is_txathr) txa_thr_o <= arg;
      if (is_rxen) rx_en_o <= 1'b1; else if (is_rxdis) rx_en_o <= 1'b0;
      if (is_txen) tx_en_o <= 1'b1; else if (is_txdis) tx_en_o <= 1'b0;
      if (is_rxen || is_rxrst || is_txen || is_txrst) busy_cnt <= BUSY_LD;
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
    end
  end

  assign status_o = {win, busy_cnt != '0, 4'b0000, lat & rzmask};
  assign irq_o    = |(lat & imask);

  p_win_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_win |=> status_o[15:13] == $past(cmd_data[2:0]));
  p_ack_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ack && evt_i == 8'h00) |=> (lat & $past(cmd_data[7:0])) == 8'h00);
  p_req_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_req |=> lat[6]);
  p_rx_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_rxdis |=> !rx_en_o);
  p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rst_o && !$past(is_rxrst) && !$past(is_grst)) |-> 1'b0);
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rxen || is_txrst) |=> status_o[12]);
  p_grst_r13: assert property (@(posedge clk) disable iff (!rst_n)
    is_grst |=> (!rx_en_o && !tx_en_o && status_o[15:13] == 3'd0 && !irq_o));
endmodule

// File: tb/test_nic_cmd_status.sv
module test_nic_cmd_status;
  logic clk = 1'b0, rst_n = 1'b0, cmd_we = 1'b0;
  logic [15:0] cmd_data = '0;
  logic [7:0]  evt_i = '0;
  logic [15:0] status_o;
  logic irq_o, rx_en_o, tx_en_o, rx_rst_o, tx_rst_o;
  logic [10:0] rxe_thr_o, txa_thr_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nic_cmd_status i_nic_cmd_status (.*);

  // {we, cmd, evt, expected status, expected irq}
  localparam logic [41:0] VEC [19] = '{
    {1'b1, 16'h78FF, 8'h00, 16'h0000, 1'b0}, // R8 open visibility
    {1'b0, 16'h0000, 8'h14, 16'h0014, 1'b0}, // R3
    {1'b1, 16'h7010, 8'h00, 16'h0014, 1'b1}, // R6
    {1'b0, 16'h0000, 8'h08, 16'h0014, 1'b1}, // R12 tx avail ignored at 2047
    {1'b1, 16'h9064, 8'h00, 16'h0014, 1'b1}, // R12 threshold 100
    {1'b0, 16'h0000, 8'h18, 16'h001D, 1'b1}, // R7 bit0 set
    {1'b1, 16'h6810, 8'h00, 16'h000D, 1'b0}, // R4
    {1'b1, 16'h0FFD, 8'h00, 16'hA00D, 1'b0}, // R2 upper arg ignored
    {1'b1, 16'h6000, 8'h00, 16'hA04D, 1'b0}, // R5
    {1'b1, 16'h780F, 8'h00, 16'hA00D, 1'b0}, // R8 hide bit 6
    {1'b1, 16'h78FF, 8'h00, 16'hA04D, 1'b0}, // R8 still latched
    {1'b1, 16'h6804, 8'h04, 16'hA04D, 1'b0}, // R4 event wins
    {1'b0, 16'h0000, 8'h41, 16'hA04D, 1'b0}, // R3 bits 0,6 ignored
    {1'b1, 16'h6FFF, 8'h00, 16'hA000, 1'b0}, // R4 ack all
    {1'b1, 16'hFFFF, 8'h00, 16'hA000, 1'b0}, // R14
    {1'b1, 16'h2000, 8'h00, 16'hB000, 1'b0}, // R11 busy 1st
    {1'b0, 16'h0000, 8'h00, 16'hB000, 1'b0}, // R11 busy 2nd
    {1'b0, 16'h0000, 8'h00, 16'hA000, 1'b0}, // R11 cleared
    {1'b1, 16'h1800, 8'h00, 16'hA000, 1'b0}  // R11 no busy on disable
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic [15:0] c, input logic [7:0] e);
    cmd_we = we; cmd_data = c; evt_i = e;
    @(posedge clk); #1;
    cmd_we = 1'b0; cmd_data = '0; evt_i = '0;
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog got=%h exp=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status", status_o, 16'h0000);
    chk("R1 irq", {15'd0, irq_o}, 16'h0000);
    chk("R1 en", {14'd0, rx_en_o, tx_en_o}, 16'h0000);
    chk("R1 thr", {5'd0, rxe_thr_o}, 16'h07FF);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < 19; i++) begin
      step(VEC[i][41], VEC[i][40:25], VEC[i][24:17]);
      chk($sformatf("vec%0d status", i), status_o, VEC[i][16:1]);
      chk($sformatf("vec%0d irq", i), {15'd0, irq_o}, {15'd0, VEC[i][0]});
    end

    // R12 rx early threshold
    step(1'b0, 16'h0000, 8'h20);
    chk("R12 rxe ignored", status_o, 16'hA000);
    step(1'b1, 16'h8840, 8'h00);
    chk("R12 rxe thr", {5'd0, rxe_thr_o}, 16'h0040);
    step(1'b0, 16'h0000, 8'h20);
    chk("R12 rxe accepted", status_o, 16'hA020);

    // R9 enables
    chk("R9 rx off", {15'd0, rx_en_o}, 16'h0000);
    step(1'b1, 16'h2000, 8'h00);
    chk("R9 rx on", {15'd0, rx_en_o}, 16'h0001);
    step(1'b1, 16'h4800, 8'h00);
    chk("R9 tx on", {15'd0, tx_en_o}, 16'h0001);
    step(1'b1, 16'h5000, 8'h00);
    chk("R9 tx off", {15'd0, tx_en_o}, 16'h0000);

    // R10 strobes
    step(1'b1, 16'h2800, 8'h00);
    chk("R10 rx strobe", {14'd0, rx_rst_o, tx_rst_o}, 16'h0002);
    step(1'b0, 16'h0000, 8'h00);
    chk("R10 rx strobe end", {14'd0, rx_rst_o, tx_rst_o}, 16'h0000);
    step(1'b1, 16'h5800, 8'h00);
    chk("R10 tx strobe", {14'd0, rx_rst_o, tx_rst_o}, 16'h0001);
    chk("R11 busy tx reset", {15'd0, status_o[12]}, 16'h0001);
    step(1'b0, 16'h0000, 8'h00);
    step(1'b0, 16'h0000, 8'h00);

    // R7 interrupt latch
    step(1'b1, 16'h68FF, 8'h00);
    chk("R4 cleared", status_o, 16'hA000);
    step(1'b0, 16'h0000, 8'h10);
    chk("R7 latch", status_o, 16'hA011);
    chk("R6 irq", {15'd0, irq_o}, 16'h0001);

    // R13 global reset
    step(1'b1, 16'h0000, 8'h00);
    chk("R13 status", status_o, 16'h1000);
    chk("R13 strobes", {14'd0, rx_rst_o, tx_rst_o}, 16'h0003);
    chk("R13 en", {14'd0, rx_en_o, tx_en_o}, 16'h0000);
    chk("R13 irq", {15'd0, irq_o}, 16'h0000);
    chk("R13 thr", {5'd0, txa_thr_o}, 16'h07FF);
    step(1'b1, 16'h78FF, 8'h00);
    step(1'b0, 16'h0000, 8'h00);
    chk("R13 flags clear", status_o, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule